// File: doc/BRIEF.md
# Synthetic Mesh Traffic Destination Generator

This block picks a destination node for every packet that a synthetic traffic source injects into a square mesh network. By default the mesh is 4x4, which gives 16 nodes with 4-bit identifiers. Each cycle it receives the injecting node's identifier, a 3-bit pattern code and an inject strobe. One cycle after each strobe it presents a registered destination identifier with a valid flag.

Two families of patterns are offered:

- **Uniform random.** The destination is taken from a 16-bit linear feedback shift register. This register is loaded from a seed input while reset is held.
- **Deterministic permutations.** Five patterns rearrange the bits of the source identifier. Two patterns shift each mesh coordinate by a fixed step.

In every node identifier, bits [1:0] hold the X coordinate and bits [3:2] hold the Y coordinate. A load generator for network evaluation can instantiate one copy of the block per node and tie `src_id` to that node's number.

Top module: `traffic_dest_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `dst_valid` is 0 and `dst_id` is 0.
- R2: `dst_valid` is 1 on the cycle after a cycle with `inject` high, and is 0 on the cycle after a cycle with `inject` low.
- R3: A cycle with `inject` low leaves `dst_id` unchanged and does not advance the shift register. The next random destination is therefore the one that would have followed anyway.
- R4: Pattern code 0 (random) yields the low 4 bits of the shift register's current value. On every cycle with `inject` high the register steps once, whatever the pattern code. The step shifts the register left by one bit and brings in bit15^bit13^bit12^bit10 as the new bit 0.
- R5: While reset is held, the shift register takes the value of `seed`. A seed of zero is replaced by 16'hACE1.
- R6: Over 65535 consecutive random injections, each nonzero destination occurs exactly 4096 times and destination 0 occurs exactly 4095 times.
- R7: Code 1 yields the bitwise inverse of the source (0001 -> 1110).
- R8: Code 2 yields the source with its bit order reversed (0011 -> 1100).
- R9: Code 3 yields the source rotated right by one bit (0001 -> 1000, 0010 -> 0001).
- R10: Code 4 yields the source rotated left by one bit (1000 -> 0001).
- R11: Code 5 swaps the upper and lower two-bit halves of the source (0111 -> 1101).
- R12: Code 6 adds k/2-1 modulo k (here 1 mod 4) to each of X and Y independently.
- R13: Code 7 adds 1 modulo 4 to each of X and Y independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the seed is loaded while it is low |
| seed | input | 16 | Start value for the random generator |
| src_id | input | 4 | Identifier of the injecting node |
| pattern | input | 3 | Traffic pattern code, 0 to 7 |
| inject | input | 1 | Request for one destination this cycle |
| dst_id | output | 4 | Registered destination identifier |
| dst_valid | output | 1 | High on the cycle after an injection |

## Verification
The shift register steps on every injection, including injections that use a permutation pattern. A permutation result and a hidden advance of the random stream therefore fall in the same cycle. The bench provokes this by interleaving permutation bursts, idle gaps and pattern switches back to random. It judges the next random destinations against its own step count and its own shift-register model. The same approach covers a zero seed followed by immediate random traffic, and a full-period run whose destination histogram is compared with the exact expected counts.

// File: rtl/traffic_dest_gen.sv
module traffic_dest_gen #(
  parameter int MESH_K = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] seed,
  input  logic [3:0]  src_id,
  input  logic [2:0]  pattern,
  input  logic        inject,
  output logic [3:0]  dst_id,
  output logic        dst_valid
);
  localparam int CW = $clog2(MESH_K);
  localparam int IW = 2 * CW;
  localparam logic [CW-1:0] TORN_STEP = CW'(MESH_K / 2 - 1);
  localparam logic [CW-1:0] NEXT_STEP = CW'(1);

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] seed_w;
  logic [IW-1:0] s, comp_d, rev_d, rotr_d, rotl_d, swap_d, torn_d, nbr_d, next_d;

  assign s      = src_id[IW-1:0];
  assign seed_w = LFSR_W'(seed);

  genvar i;
  generate
    for (i = 0; i < IW; i++) begin : g_bitperm
      assign comp_d[i] = ~s[i];
      assign rev_d[i]  = s[IW-1-i];
      assign rotr_d[i] = s[(i+1) % IW];
      assign rotl_d[i] = s[(i+IW-1) % IW];
      assign swap_d[i] = s[(i+IW/2) % IW];
    end
  endgenerate

  assign torn_d = {s[IW-1:CW] + TORN_STEP, s[CW-1:0] + TORN_STEP};
  assign nbr_d  = {s[IW-1:CW] + NEXT_STEP, s[CW-1:0] + NEXT_STEP};

  always_comb begin
    case (pattern)
      3'd1:    next_d = comp_d;
      3'd2:    next_d = rev_d;
      3'd3:    next_d = rotr_d;
      3'd4:    next_d = rotl_d;
      3'd5:    next_d = swap_d;
      3'd6:    next_d = torn_d;
      3'd7:    next_d = nbr_d;
      default: next_d = lfsr[IW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr      <= (seed_w == '0) ? SEED_FALLBACK : seed_w;
      dst_id    <= '0;
      dst_valid <= 1'b0;
    end else begin
      dst_valid <= inject;
      if (inject) begin
        dst_id <= 4'(next_d);
        lfsr   <= {lfsr[LFSR_W-2:0], ^(lfsr & TAP_MASK)};
      end
    end
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0);

  // R2
  valid_after_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> dst_valid);

  // R2
  no_valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inject |=> !dst_valid);

  // R3
  idle_holds_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inject |=> $stable(dst_id));

  // R7
  bitcomp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && pattern == 3'd1) |=> dst_id == ~$past(src_id));

  // R13
  neighbor_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && pattern == 3'd7) |=> dst_id[1:0] == 2'($past(src_id[1:0]) + 2'd1));
endmodule

// File: tb/traffic_dest_gen_tb.sv
module traffic_dest_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] seed = 16'h1234;
  logic [3:0] src_id = '0;
  logic [2:0] pattern = '0;
  logic inject = 1'b0;
  logic [3:0] dst_id;
  logic dst_valid;

  int checks = 0;
  int errors = 0;
  int lfsr_m;
  int exp_d;
  int hist[16];

  always #2.5 clk = ~clk;

  traffic_dest_gen u_dut (
    .clk(clk), .rst_n(rst_n), .seed(seed), .src_id(src_id),
    .pattern(pattern), .inject(inject), .dst_id(dst_id), .dst_valid(dst_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int lfsr_step(input int v);
    int fb;
    fb = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
    return ((v << 1) & 16'hFFFF) | fb;
  endfunction

  function automatic int perm(input int pat, input int s, input int r);
    int x, y, o;
    x = s % 4;
    y = s / 4;
    case (pat)
      0: return r % 16;
      1: return 15 - s;
      2: begin
        o = 0;
        for (int b = 0; b < 4; b++) if ((s >> b) & 1) o += 1 << (3 - b);
        return o;
      end
      3: return (s >> 1) + (s % 2) * 8;
      4: return (s * 2) % 16 + s / 8;
      5: return (s % 4) * 4 + s / 4;
      6: return ((y + 1) % 4) * 4 + (x + 1) % 4;
      default: return ((y + 1) % 4) * 4 + (x + 1) % 4;
    endcase
  endfunction

  function automatic string tag_of(input int pat);
    case (pat)
      0: return "R4";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R10";
      5: return "R11";
      6: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic do_reset(input int sd);
    rst_n = 1'b0;
    inject = 1'b0;
    seed = 16'(sd);
    lfsr_m = (sd == 0) ? 16'hACE1 : sd;
    exp_d = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dst_valid == 1'b0, "R1 valid in reset", int'(dst_valid), 0);
    chk(dst_id == 4'd0, "R1 dest in reset", int'(dst_id), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(dst_valid == 1'b0, "R1 valid after release", int'(dst_valid), 0);
    chk(dst_id == 4'd0, "R1 dest after release", int'(dst_id), 0);
  endtask

  task automatic step(input bit inj, input int pat, input int src, input string tag);
    string t;
    inject = inj;
    pattern = 3'(pat);
    src_id = 4'(src);
    if (inj) begin
      exp_d = perm(pat, src, lfsr_m);
      lfsr_m = lfsr_step(lfsr_m);
    end
    t = (tag != "") ? tag : (inj ? tag_of(pat) : "R3");
    @(posedge clk);
    @(negedge clk);
    chk(dst_valid == inj, "R2 valid", int'(dst_valid), int'(inj));
    chk(int'(dst_id) == exp_d, t, int'(dst_id), exp_d);
  endtask

  initial begin
    do_reset(16'h1234);
    for (int p = 1; p < 8; p++)
      for (int s = 0; s < 16; s++) step(1'b1, p, s, "");
    step(1'b1, 1, 1, "R7 0001");
    step(1'b1, 2, 3, "R8 0011");
    step(1'b1, 3, 2, "R9 0010");
    step(1'b1, 4, 8, "R10 1000");
    step(1'b1, 5, 7, "R11 0111");
    step(1'b1, 6, 15, "R12 wrap");
    step(1'b1, 7, 3, "R13 wrap");
    for (int n = 0; n < 40; n++) step(1'b1, 0, n % 16, "R4");
    for (int n = 0; n < 30; n++) begin
      step(1'b1, 1 + n % 7, (n * 5) % 16, "");
      step(1'b0, n % 8, n % 16, "R3");
      if (n % 3 == 0) step(1'b0, 0, 0, "R3");
      step(1'b1, 0, n % 16, "R4 after mixed");
    end
    do_reset(0);
    for (int n = 0; n < 8; n++) step(1'b1, 0, 0, "R5 zero seed");
    do_reset(16'hBEEF);
    step(1'b1, 0, 0, "R5 seed");
    do_reset(16'h0001);
    foreach (hist[k]) hist[k] = 0;
    for (int n = 0; n < 65535; n++) begin
      step(1'b1, 0, n % 16, "R4");
      hist[dst_id]++;
    end
    for (int k = 0; k < 16; k++)
      chk(hist[k] == ((k == 0) ? 4095 : 4096), "R6 histogram", hist[k], (k == 0) ? 4095 : 4096);
    inject = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule